// File: doc/BRIEF.md
# Receive Character Queue with Overflow Holding Slot

This block sits between a serial receiver and a CPU read port. Each finished character arrives with eight data bits and three status flags: break, framing error and parity error. The block stores it in a queue of `DEPTH` entries, 256 by default. When the queue is full, one more character can wait in a holding slot that stands for the receive shift register. The block can therefore hold `DEPTH + 1` characters.

The CPU pops characters one at a time with a read strobe. The popped character and its flags appear at the read outputs one cycle later. If a character is waiting in the holding slot, it drops into the queue in the same cycle as the read, so the queue stays full until a second read. The receiver also sends a start-bit strobe. If that strobe arrives while the queue is full and a character is already waiting, the waiting character is lost and a sticky overrun flag is raised. Only an explicit error-clear command lowers the overrun flag.

Three registered status outputs summarise the state: data available, queue full, and overrun.

Top module: `rxq_top`

## Requirements
- R1: After reset, `rxRdy`, `rxFull` and `overrun` are all 0.
- R2: Characters leave in arrival order. Each one keeps its flags: break on `rdBreak`, framing on `rdFrame`, parity on `rdParity`, data on `rdData`. All four are registered and valid in the cycle after the accepted read strobe.
- R3: `rxRdy` goes to 1 in the cycle after a character enters the queue. It goes to 0 after a read that leaves the queue empty.
- R4: `rxFull` goes to 1 only after the write that occupies the last of the `DEPTH` positions. It stays 0 while at least one position is free.
- R5: A character that arrives while the queue is full waits in the holding slot. The first read moves it into the queue in the same cycle, so `rxFull` stays 1. The second read clears `rxFull`. The held character is read out after all earlier characters.
- R6: A `startBit` pulse arrives while the queue is full, a character is waiting and no read is made in the same cycle. Then `overrun` goes to 1 and the waiting character with its flags is discarded.
- R7: A `startBit` pulse while the queue is not full, or while it is full with no character waiting, leaves `overrun` at 0.
- R8: `overrun` stays 1 through reads. It returns to 0 only in the cycle after `clrErr`.
- R9: A read and a character arrival in the same cycle are both honoured, and the occupancy stays the same.
- R10: A read strobe on an empty queue leaves the read outputs and all status unchanged.
- R11: A character arrives while another is already waiting and no read is made. It replaces the waiting character, and `overrun` goes to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chValid | input | 1 | Receiver delivers a finished character this cycle |
| chData | input | 8 | Received data bits |
| chFrame | input | 1 | Framing error flag of the delivered character |
| chParity | input | 1 | Parity error flag of the delivered character |
| chBreak | input | 1 | Break flag of the delivered character |
| startBit | input | 1 | Receiver has detected a new start bit |
| rdStrobe | input | 1 | CPU read of the queue head |
| clrErr | input | 1 | Error-clear command, lowers the overrun flag |
| rdData | output | 8 | Data of the last popped character |
| rdFrame | output | 1 | Framing flag of the last popped character |
| rdParity | output | 1 | Parity flag of the last popped character |
| rdBreak | output | 1 | Break flag of the last popped character |
| rxRdy | output | 1 | At least one character is in the queue |
| rxFull | output | 1 | All queue positions are occupied |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The queue is first exercised with one character, then with a combined read and write in one cycle, and then filled to capacity. The single-character case shows that data flags and the ready bit move together. The combined case shows that occupancy is held rather than counted twice. Three runs go past capacity, each continued in a different way:
- reads only, which shows the held character refilling the queue and full clearing only on the second read;
- a start bit, which shows the held character being dropped because the first read then clears full;
- a second arrival, which shows the held character being replaced.

Each of these runs drains the queue and checks the order, which catches a lost or duplicated entry at the pointer wrap.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int CHAR_W = 8;

  typedef struct packed {
    logic              brk;
    logic              frame;
    logic              parity;
    logic [CHAR_W-1:0] data;
  } rxqChar_t;

  typedef struct packed {
    logic pushIn;    // write the incoming character into the queue
    logic pushHold;  // write the held character into the queue
    logic loadHold;  // capture the incoming character in the holding slot
    logic pop;       // advance the read side and register the head
  } rxqStrb_t;

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     chValid,
  input  logic     startBit,
  input  logic     rdStrobe,
  input  logic     clrErr,
  output rxqStrb_t strb,
  output logic     rxRdy,
  output logic     rxFull,
  output logic     overrun
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  logic [CNT_W-1:0] count, countNext;
  logic             holdValid, holdValidNext;
  logic             isFull, isEmpty, canPop, hasSpace;
  logic             dropStart, dropReplace, push;

  assign isFull  = (count == FULL_CNT);
  assign isEmpty = (count == '0);
  assign canPop  = rdStrobe && !isEmpty;

  // an incoming character finds room if a slot is free, or if this cycle's
  // read frees one that the held character does not take
  assign hasSpace = !isFull || (canPop && !holdValid);

  always_comb begin
    strb          = '0;
    strb.pop      = canPop;
    strb.pushHold = holdValid && canPop;
    if (chValid) begin
      if (hasSpace) strb.pushIn   = 1'b1;
      else          strb.loadHold = 1'b1;
    end
  end

  assign push        = strb.pushIn || strb.pushHold;
  assign dropStart   = startBit && holdValid && !canPop;
  assign dropReplace = chValid && holdValid && !canPop;

  always_comb begin
    countNext = count;
    if (push && !strb.pop)      countNext = count + ONE_CNT;
    else if (!push && strb.pop) countNext = count - ONE_CNT;
  end

  always_comb begin
    holdValidNext = holdValid;
    if (strb.pushHold || dropStart) holdValidNext = 1'b0;
    if (strb.loadHold)              holdValidNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count     <= '0;
      holdValid <= 1'b0;
      rxRdy     <= 1'b0;
      rxFull    <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      count     <= countNext;
      holdValid <= holdValidNext;
      rxRdy     <= (countNext != '0);
      rxFull    <= (countNext == FULL_CNT);
      if (dropStart || dropReplace) overrun <= 1'b1;
      else if (clrErr)              overrun <= 1'b0;
    end
  end

  a_r5_hold_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    holdValid |-> (count == FULL_CNT));

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  a_r4_full_after_push: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxFull) |-> $past(push));

  a_r5_refill_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    (holdValid && canPop) |=> rxFull);

  a_r6_start_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (startBit && holdValid && !canPop) |=> overrun);

  a_r8_sticky_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overrun) |-> $past(clrErr));

  a_r3_ready_falls_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rxRdy) |-> $past(canPop));

endmodule

// File: rtl/rxq_data.sv
module rxq_data
  import rxq_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic     clk,
  input  logic     rst_n,
  input  rxqStrb_t strb,
  input  rxqChar_t inChar,
  output rxqChar_t outChar
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  rxqChar_t         mem [DEPTH];
  rxqChar_t         holdReg;
  rxqChar_t         wrChar;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             wrEn;

  assign wrEn   = strb.pushIn || strb.pushHold;
  assign wrChar = strb.pushHold ? holdReg : inChar;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrPtr] <= wrChar;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      holdReg <= '0;
      outChar <= '0;
    end else begin
      if (wrEn)          wrPtr   <= nextPtr(wrPtr);
      if (strb.loadHold) holdReg <= inChar;
      if (strb.pop) begin
        outChar <= mem[rdPtr];
        rdPtr   <= nextPtr(rdPtr);
      end
    end
  end

  a_r10_idle_output: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.pop |=> $stable(outChar));

  a_r5_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.pushIn && strb.pushHold));

endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chValid,
  input  logic [CHAR_W-1:0] chData,
  input  logic              chFrame,
  input  logic              chParity,
  input  logic              chBreak,
  input  logic              startBit,
  input  logic              rdStrobe,
  input  logic              clrErr,
  output logic [CHAR_W-1:0] rdData,
  output logic              rdFrame,
  output logic              rdParity,
  output logic              rdBreak,
  output logic              rxRdy,
  output logic              rxFull,
  output logic              overrun
);

  rxqStrb_t strb;
  rxqChar_t inChar, outChar;

  assign inChar = '{brk: chBreak, frame: chFrame, parity: chParity, data: chData};

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .chValid  (chValid),
    .startBit (startBit),
    .rdStrobe (rdStrobe),
    .clrErr   (clrErr),
    .strb     (strb),
    .rxRdy    (rxRdy),
    .rxFull   (rxFull),
    .overrun  (overrun)
  );

  rxq_data #(.DEPTH(DEPTH)) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .inChar  (inChar),
    .outChar (outChar)
  );

  assign rdData   = outChar.data;
  assign rdFrame  = outChar.frame;
  assign rdParity = outChar.parity;
  assign rdBreak  = outChar.brk;

endmodule

// File: tb/rxq_top_tb.sv
module rxq_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 256;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       chValid, chFrame, chParity, chBreak, startBit, rdStrobe, clrErr;
  logic [7:0] chData, rdData;
  logic       rdFrame, rdParity, rdBreak, rxRdy, rxFull, overrun;

  int errCount = 0;
  int chkCount = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rxq_top #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .chValid(chValid), .chData(chData),
    .chFrame(chFrame), .chParity(chParity), .chBreak(chBreak),
    .startBit(startBit), .rdStrobe(rdStrobe), .clrErr(clrErr),
    .rdData(rdData), .rdFrame(rdFrame), .rdParity(rdParity), .rdBreak(rdBreak),
    .rxRdy(rxRdy), .rxFull(rxFull), .overrun(overrun)
  );

  // {break, frame, parity, data}
  function automatic logic [10:0] pat(input int i);
    return {1'(i % 7 == 3), 1'(i % 5 == 1), 1'(i % 3 == 2), 8'(i * 37 + 5)};
  endfunction

  function automatic logic [10:0] outChar();
    return {rdBreak, rdFrame, rdParity, rdData};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    chkCount++;
    if (!ok) begin
      errCount++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // one cycle of stimulus; entered and left just after a falling edge
  task automatic cyc(input bit v, input logic [10:0] c, input bit sb,
                     input bit rd, input bit clr);
    chValid  = v;
    chBreak  = c[10];
    chFrame  = c[9];
    chParity = c[8];
    chData   = c[7:0];
    startBit = sb;
    rdStrobe = rd;
    clrErr   = clr;
    @(negedge clk);
    chValid  = 1'b0;
    startBit = 1'b0;
    rdStrobe = 1'b0;
    clrErr   = 1'b0;
  endtask

  task automatic push(input logic [10:0] c); cyc(1'b1, c, 1'b0, 1'b0, 1'b0); endtask
  task automatic rd();                       cyc(1'b0, '0, 1'b0, 1'b1, 1'b0); endtask

  task automatic fill(input int base);
    for (int i = 0; i < DEPTH; i++) push(pat(base + i));
  endtask

  // reads n characters expecting pat(base + k); returns the mismatch count
  task automatic drain(input int base, input int n, output int bad);
    bad = 0;
    for (int k = 0; k < n; k++) begin
      rd();
      if (outChar() !== pat(base + k)) bad++;
    end
  endtask

  task automatic t_reset();
    chk(rxRdy === 1'b0,   "R1", "rxRdy after reset",   32'(rxRdy),   0);
    chk(rxFull === 1'b0,  "R1", "rxFull after reset",  32'(rxFull),  0);
    chk(overrun === 1'b0, "R1", "overrun after reset", 32'(overrun), 0);
  endtask

  task automatic t_single();
    push(pat(1));
    chk(rxRdy === 1'b1, "R3", "rxRdy after one write", 32'(rxRdy), 1);
    chk(rxFull === 1'b0, "R4", "rxFull with one entry", 32'(rxFull), 0);
    rd();
    chk(outChar() === pat(1), "R2", "char and flags", 32'(outChar()), 32'(pat(1)));
    chk(rxRdy === 1'b0, "R3", "rxRdy after emptying read", 32'(rxRdy), 0);
  endtask

  task automatic t_empty_read();
    rd();
    chk(outChar() === pat(1), "R10", "output after empty read", 32'(outChar()), 32'(pat(1)));
    chk({rxRdy, rxFull, overrun} === 3'b000, "R10", "status after empty read",
        32'({rxRdy, rxFull, overrun}), 0);
  endtask

  task automatic t_same_cycle();
    push(pat(2));
    cyc(1'b1, pat(3), 1'b0, 1'b1, 1'b0);
    chk(outChar() === pat(2), "R9", "popped char in shared cycle", 32'(outChar()), 32'(pat(2)));
    chk(rxRdy === 1'b1, "R9", "one entry remains", 32'(rxRdy), 1);
    rd();
    chk(outChar() === pat(3), "R9", "written char in shared cycle", 32'(outChar()), 32'(pat(3)));
    chk(rxRdy === 1'b0, "R9", "empty after second read", 32'(rxRdy), 0);
  endtask

  task automatic t_full_hold();
    int bad;
    for (int i = 0; i < DEPTH - 1; i++) push(pat(100 + i));
    chk(rxFull === 1'b0, "R4", "rxFull one slot short", 32'(rxFull), 0);
    push(pat(100 + DEPTH - 1));
    chk(rxFull === 1'b1, "R4", "rxFull at capacity", 32'(rxFull), 1);
    cyc(1'b0, '0, 1'b1, 1'b0, 1'b0);
    chk(overrun === 1'b0, "R7", "start bit full, nothing held", 32'(overrun), 0);
    push(pat(100 + DEPTH));
    chk(rxFull === 1'b1, "R5", "rxFull with held char", 32'(rxFull), 1);
    rd();
    chk(outChar() === pat(100), "R5", "first read head", 32'(outChar()), 32'(pat(100)));
    chk(rxFull === 1'b1, "R5", "rxFull after first read", 32'(rxFull), 1);
    rd();
    chk(rxFull === 1'b0, "R5", "rxFull after second read", 32'(rxFull), 0);
    chk(outChar() === pat(101), "R2", "second read order", 32'(outChar()), 32'(pat(101)));
    drain(102, DEPTH - 1, bad);
    chk(bad == 0, "R5", "drain order incl. held char", 32'(bad), 0);
    chk(rxRdy === 1'b0, "R3", "empty after drain", 32'(rxRdy), 0);
    cyc(1'b0, '0, 1'b1, 1'b0, 1'b0);
    chk(overrun === 1'b0, "R7", "start bit on empty queue", 32'(overrun), 0);
  endtask

  task automatic t_overrun();
    int bad;
    fill(500);
    push(pat(999));
    cyc(1'b0, '0, 1'b1, 1'b0, 1'b0);
    chk(overrun === 1'b1, "R6", "overrun on start bit", 32'(overrun), 1);
    rd();
    chk(rxFull === 1'b0, "R6", "held char discarded", 32'(rxFull), 0);
    chk(overrun === 1'b1, "R8", "overrun held through read", 32'(overrun), 1);
    drain(501, DEPTH - 1, bad);
    chk(bad == 0, "R6", "remaining order", 32'(bad), 0);
    chk(rxRdy === 1'b0, "R6", "nothing left after discard", 32'(rxRdy), 0);
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b1);
    chk(overrun === 1'b0, "R8", "overrun cleared by command", 32'(overrun), 0);
  endtask

  task automatic t_replace();
    int bad;
    fill(2000);
    push(pat(7));
    chk(overrun === 1'b0, "R11", "no overrun on first held char", 32'(overrun), 0);
    push(pat(8));
    chk(overrun === 1'b1, "R11", "overrun on replacement", 32'(overrun), 1);
    drain(2000, DEPTH, bad);
    chk(bad == 0, "R11", "queued chars intact", 32'(bad), 0);
    rd();
    chk(outChar() === pat(8), "R11", "held char is newest", 32'(outChar()), 32'(pat(8)));
    chk(rxRdy === 1'b0, "R11", "empty after held char", 32'(rxRdy), 0);
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0;
    chValid = 1'b0; startBit = 1'b0; rdStrobe = 1'b0; clrErr = 1'b0;
    chData = '0; chFrame = 1'b0; chParity = 1'b0; chBreak = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_empty_read();
    t_same_cycle();
    t_full_hold();
    t_overrun();
    t_replace();
    $display("Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errCount++;
    chkCount++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  end

endmodule